// File: doc/BRIEF.md
# Receive Lane Power Sequencer

This block brings one serial-link receive lane out of its powered-down state and puts it back, by stepping a 32-bit PHY control word through a fixed series of single-bit changes. Minimum gaps, counted in clock cycles, separate the steps that need them. The PHY signals back when calibration has finished. The PCS supplies a link-status flag that the sequencer waits for and then clears by pulsing a write-one-to-clear strobe. A separate command runs a short transmit-lane enable handshake before the link is used.

Each command is a one-cycle pulse, and a run ends with a one-cycle `done` or `err`. While a run is in progress, further commands are dropped. Every delay and every timeout is a parameter in clock cycles, so a simulation can use short values while a chip uses wall-clock lengths in the range of milliseconds and seconds.

Top module: `rx_lane_seq`

## Requirements
- R1: Reset sets the control word to 0x800000F0: override (bit 31), both sleep bits (7:6), auxiliary IDDQ (bit 5) and receiver IDDQ (bit 4) are set, and all other bits are clear. Reset also holds `busy`, `done`, `err`, `link_clr` and `tx_en` low.
- R2: A power-up command first sets override (bit 31). It then clears receiver IDDQ (bit 4), then auxiliary IDDQ (bit 5), then both sleep bits (7:6), and then sets calibration enable (bit 8), in that order.
- R3: When `cal_clr` reports that calibration has finished, bit 8 is cleared. The sequencer then sets data enable (bit 0), clears PHY-ready (bit 10), sets CDR reset (bit 9), sets PHY-ready, and finally clears CDR reset, in that order.
- R4: At least GAP_SHORT cycles separate each of these pairs of steps: auxiliary IDDQ clear and sleep clear; calibration finish and data enable; PHY-ready clear and CDR reset set; CDR reset set and PHY-ready set. At least GAP_LONG cycles separate sleep clear and calibration enable.
- R5: CDR reset stays set for at least CDR_HOLD cycles after PHY-ready is set.
- R6: After CDR reset is released, the sequencer waits for `link_sts`. When it sees the flag, it pulses `link_clr` for exactly one cycle, in the same cycle as `done`.
- R7: If calibration does not finish within CAL_TMO cycles, or `link_sts` does not arrive within LINK_TMO cycles, the sequencer pulses `err`, leaves the control word as it stands, and returns to idle.
- R8: A power-down command sets override, clears data enable, sets both sleep bits, sets auxiliary IDDQ and then sets receiver IDDQ, and then pulses `done`. Bits that already hold their target value are left unchanged.
- R9: `busy` is high from the cycle after a command is accepted until the cycle in which `done` or `err` pulses. `done` and `err` are never high together. A command that arrives while `busy` is high has no effect.
- R10: A transmit command pulses `done` without raising `tx_en` if `tx_pwr_up` is high. Otherwise it raises `tx_en` and holds it until `tx_ack`, then drops it and pulses `done`. If `tx_ack` does not arrive within TX_TMO cycles, it pulses `err` and leaves `tx_en` high.
- R11: If several commands arrive in the same idle cycle, power-up wins over power-down, and power-down wins over the transmit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_cmd | input | 1 | Power-up command pulse |
| down_cmd | input | 1 | Power-down command pulse |
| tx_cmd | input | 1 | Transmit-lane enable command pulse |
| cal_clr | input | 1 | PHY reports that calibration enable has self-cleared |
| link_sts | input | 1 | PCS link-status flag |
| tx_pwr_up | input | 1 | Transmit lane already powered |
| tx_ack | input | 1 | PHY reports that the transmit-enable bit has self-cleared |
| ctrl | output | 32 | Receive-lane PHY control word |
| link_clr | output | 1 | Write-one-to-clear strobe for the link-status flag |
| tx_en | output | 1 | Transmit-enable request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence succeeds |
| err | output | 1 | One-cycle pulse when a sequence times out |

## Verification
The power-up sequence is run with a PHY model that answers calibration and link, and every distinct value that the control word takes is recorded with its cycle. The recorded list tells a wrong step order apart from a missing step. The recorded cycles are compared against the gap and hold parameters. Further runs stop the calibration reply or the link flag, which separates a correct timeout from a hang, or from a sequence that carries on regardless. Power-down is started both from the fully-up word and from the reset word, which separates step ordering from needless toggling. Commands that overlap a run, or arrive in the same cycle, and the three transmit cases check acceptance and priority.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

   localparam int CTRL_W = 32;

   localparam logic [31:0] M_OVRD = 32'h8000_0000;
   localparam logic [31:0] M_RDY  = 32'h0000_0400;
   localparam logic [31:0] M_CDR  = 32'h0000_0200;
   localparam logic [31:0] M_CAL  = 32'h0000_0100;
   localparam logic [31:0] M_SLP  = 32'h0000_00C0;
   localparam logic [31:0] M_AUX  = 32'h0000_0020;
   localparam logic [31:0] M_IDDQ = 32'h0000_0010;
   localparam logic [31:0] M_DATA = 32'h0000_0001;

   localparam logic [31:0] CTRL_OFF = M_OVRD | M_SLP | M_AUX | M_IDDQ;

   typedef enum logic [4:0] {
      S_IDLE,
      S_UP_OVRD, S_UP_IDDQ, S_UP_AUX, S_UP_W1, S_UP_SLP, S_UP_W2,
      S_UP_CAL, S_UP_CALW, S_UP_W3, S_UP_DATA, S_UP_RDYLO, S_UP_W4,
      S_UP_CDR, S_UP_W5, S_UP_RDYHI, S_UP_HOLD, S_UP_CDRREL, S_UP_LINK,
      S_DN_OVRD, S_DN_DATA, S_DN_SLP, S_DN_AUX, S_DN_IDDQ,
      S_TX_CHK, S_TX_W
   } seq_st_e;

endpackage

// File: rtl/rxls_timer.sv
module rxls_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] ld_val,
   output logic          zero
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= ld_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R4: a running count steps down by exactly one per cycle
   assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R4: an expired count stays expired until reloaded
   assert_timer_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rxls_ctrl_reg.sv
module rxls_ctrl_reg #(
   parameter int          W        = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_m,
   input  logic [W-1:0] clr_m,
   output logic [W-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= RST_VAL;
      else        word <= (word & ~clr_m) | set_m;
   end

   // R2: the sequencer never sets and clears the same bit in one step
   assert_mask_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_m & clr_m) == '0));

   // R8: bits outside both masks hold their value
   assert_bits_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((word & ~($past(set_m) | $past(clr_m))) ==
                ($past(word) & ~($past(set_m) | $past(clr_m)))));

endmodule

// File: rtl/rx_lane_seq.sv
module rx_lane_seq
   import rxls_pkg::*;
#(
   parameter int GAP_SHORT    = 16,
   parameter int GAP_LONG     = 128,
   parameter int CDR_HOLD     = 7_500_000,
   parameter int CAL_TMO      = 500_000_000,
   parameter int LINK_TMO     = 250_000_000,
   parameter int TX_TMO       = 250_000_000,
   parameter bit TX_HANDSHAKE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_cmd,
   input  logic              down_cmd,
   input  logic              tx_cmd,
   input  logic              cal_clr,
   input  logic              link_sts,
   input  logic              tx_pwr_up,
   input  logic              tx_ack,
   output logic [CTRL_W-1:0] ctrl,
   output logic              link_clr,
   output logic              tx_en,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam int M1   = (GAP_SHORT > GAP_LONG) ? GAP_SHORT : GAP_LONG;
   localparam int M2   = (M1 > CDR_HOLD) ? M1 : CDR_HOLD;
   localparam int M3   = (M2 > CAL_TMO) ? M2 : CAL_TMO;
   localparam int M4   = (M3 > LINK_TMO) ? M3 : LINK_TMO;
   localparam int MAXV = (M4 > TX_TMO) ? M4 : TX_TMO;
   localparam int TW   = $clog2(MAXV + 1);

   localparam logic [TW-1:0] LD_GS   = TW'(GAP_SHORT - 1);
   localparam logic [TW-1:0] LD_GL   = TW'(GAP_LONG - 1);
   localparam logic [TW-1:0] LD_HOLD = TW'(CDR_HOLD - 1);
   localparam logic [TW-1:0] LD_CAL  = TW'(CAL_TMO - 1);
   localparam logic [TW-1:0] LD_LINK = TW'(LINK_TMO - 1);
   localparam logic [TW-1:0] LD_TX   = TW'(TX_TMO - 1);

   initial begin
      assert (GAP_SHORT >= 1 && GAP_LONG >= 1 && CDR_HOLD >= 1)
         else $error("rx_lane_seq: delays must be at least one cycle");
      assert (CAL_TMO >= 2 && LINK_TMO >= 2 && TX_TMO >= 2)
         else $error("rx_lane_seq: timeouts must be at least two cycles");
   end

   seq_st_e           st_q, st_d;
   logic [CTRL_W-1:0] set_m, clr_m;
   logic              t_load, t_zero;
   logic [TW-1:0]     t_val;
   logic              done_d, err_d, lclr_d, tx_set, tx_clr;
   logic              done_q, err_q, lclr_q, tx_en_q;
   logic              tx_go;

   generate
      if (TX_HANDSHAKE) begin : g_tx
         assign tx_go = tx_cmd;
      end else begin : g_notx
         assign tx_go = 1'b0;
      end
   endgenerate

   rxls_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load), .ld_val(t_val), .zero(t_zero)
   );

   rxls_ctrl_reg #(.W(CTRL_W), .RST_VAL(CTRL_OFF)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .set_m(set_m), .clr_m(clr_m), .word(ctrl)
   );

   always_comb begin
      st_d   = st_q;
      set_m  = '0;
      clr_m  = '0;
      t_load = 1'b0;
      t_val  = '0;
      done_d = 1'b0;
      err_d  = 1'b0;
      lclr_d = 1'b0;
      tx_set = 1'b0;
      tx_clr = 1'b0;
      unique case (st_q)
         S_IDLE: begin
            if (up_cmd)        st_d = S_UP_OVRD;
            else if (down_cmd) st_d = S_DN_OVRD;
            else if (tx_go)    st_d = S_TX_CHK;
         end
         S_UP_OVRD:  begin set_m = M_OVRD; st_d = S_UP_IDDQ; end
         S_UP_IDDQ:  begin clr_m = M_IDDQ; st_d = S_UP_AUX; end
         S_UP_AUX:   begin clr_m = M_AUX; t_load = 1'b1; t_val = LD_GS; st_d = S_UP_W1; end
         S_UP_W1:    if (t_zero) st_d = S_UP_SLP;
         S_UP_SLP:   begin clr_m = M_SLP; t_load = 1'b1; t_val = LD_GL; st_d = S_UP_W2; end
         S_UP_W2:    if (t_zero) st_d = S_UP_CAL;
         S_UP_CAL:   begin set_m = M_CAL; t_load = 1'b1; t_val = LD_CAL; st_d = S_UP_CALW; end
         S_UP_CALW: begin
            if (cal_clr) begin
               clr_m  = M_CAL;
               t_load = 1'b1;
               t_val  = LD_GS;
               st_d   = S_UP_W3;
            end else if (t_zero) begin
               err_d = 1'b1;
               st_d  = S_IDLE;
            end
         end
         S_UP_W3:    if (t_zero) st_d = S_UP_DATA;
         S_UP_DATA:  begin set_m = M_DATA; st_d = S_UP_RDYLO; end
         S_UP_RDYLO: begin clr_m = M_RDY; t_load = 1'b1; t_val = LD_GS; st_d = S_UP_W4; end
         S_UP_W4:    if (t_zero) st_d = S_UP_CDR;
         S_UP_CDR:   begin set_m = M_CDR; t_load = 1'b1; t_val = LD_GS; st_d = S_UP_W5; end
         S_UP_W5:    if (t_zero) st_d = S_UP_RDYHI;
         S_UP_RDYHI: begin set_m = M_RDY; t_load = 1'b1; t_val = LD_HOLD; st_d = S_UP_HOLD; end
         S_UP_HOLD:  if (t_zero) st_d = S_UP_CDRREL;
         S_UP_CDRREL: begin clr_m = M_CDR; t_load = 1'b1; t_val = LD_LINK; st_d = S_UP_LINK; end
         S_UP_LINK: begin
            if (link_sts) begin
               lclr_d = 1'b1;
               done_d = 1'b1;
               st_d   = S_IDLE;
            end else if (t_zero) begin
               err_d = 1'b1;
               st_d  = S_IDLE;
            end
         end
         S_DN_OVRD: begin set_m = M_OVRD; st_d = S_DN_DATA; end
         S_DN_DATA: begin clr_m = M_DATA; st_d = S_DN_SLP; end
         S_DN_SLP:  begin set_m = M_SLP;  st_d = S_DN_AUX; end
         S_DN_AUX:  begin set_m = M_AUX;  st_d = S_DN_IDDQ; end
         S_DN_IDDQ: begin set_m = M_IDDQ; done_d = 1'b1; st_d = S_IDLE; end
         S_TX_CHK: begin
            if (tx_pwr_up) begin
               done_d = 1'b1;
               st_d   = S_IDLE;
            end else begin
               tx_set = 1'b1;
               t_load = 1'b1;
               t_val  = LD_TX;
               st_d   = S_TX_W;
            end
         end
         S_TX_W: begin
            if (tx_ack) begin
               tx_clr = 1'b1;
               done_d = 1'b1;
               st_d   = S_IDLE;
            end else if (t_zero) begin
               err_d = 1'b1;
               st_d  = S_IDLE;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         lclr_q  <= 1'b0;
         tx_en_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
         err_q  <= err_d;
         lclr_q <= lclr_d;
         if (tx_set)      tx_en_q <= 1'b1;
         else if (tx_clr) tx_en_q <= 1'b0;
      end
   end

   assign busy     = (st_q != S_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign link_clr = lclr_q;
   assign tx_en    = tx_en_q;

   // R9: busy only ends with a completion or error pulse
   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done || err));

   // R9: completion and error never coincide
   assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R6: the link clear strobe accompanies completion
   assert_lclr_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      link_clr |-> done);

   // R2: calibration starts only with the lane fully awake
   assert_cal_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[8]) |-> (ctrl[31] && ctrl[7:6] == 2'b00 && !ctrl[5] && !ctrl[4]));

   // R3: data enable follows calibration completion
   assert_data_after_cal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[0]) |-> (!ctrl[8] && !ctrl[4]));

   // R3: CDR reset rises with data on and PHY-ready low
   assert_cdr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[9]) |-> (ctrl[0] && !ctrl[10]));

   // R8: receiver IDDQ is the last power-down step
   assert_iddq_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl[4]) |-> (ctrl[7:6] == 2'b11 && ctrl[5] && !ctrl[0]));

   // R10: transmit enable drops only after an acknowledge
   assert_tx_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> $past(tx_ack));

endmodule

// File: tb/sim_rx_lane_seq.sv
`timescale 1ns/1ps
module sim_rx_lane_seq;
   localparam int GS = 3, GL = 6, HOLD = 10, CALT = 40, LINKT = 50, TXT = 30;

   localparam logic [31:0] UP_EXP [9] = '{
      32'h800000E0, 32'h800000C0, 32'h80000000, 32'h80000100, 32'h80000000,
      32'h80000001, 32'h80000201, 32'h80000601, 32'h80000401 };
   localparam logic [31:0] DN_EXP [4] = '{
      32'h80000400, 32'h800004C0, 32'h800004E0, 32'h800004F0 };

   logic clk = 1'b0, rst_n = 1'b0;
   logic up_cmd = 0, down_cmd = 0, tx_cmd = 0;
   logic cal_clr, link_sts = 0, tx_pwr_up = 0, tx_ack;
   logic [31:0] ctrl;
   logic link_clr, tx_en, busy, done, err;

   logic cal_ok = 1, tx_ok = 1;
   int   cc = 0, tc = 0;
   int   checks = 0, fails = 0, cyc = 0;
   logic [31:0] ch_val [32];
   int   ch_t [32];
   int   n_ch = 0, done_cnt = 0, err_cnt = 0, clr_cnt = 0, clr_bad = 0;
   logic tx_seen = 0, finished = 0;
   logic [31:0] prev = 32'h800000F0;

   always #2.5 clk = ~clk;

   rx_lane_seq #(.GAP_SHORT(GS), .GAP_LONG(GL), .CDR_HOLD(HOLD), .CAL_TMO(CALT),
                 .LINK_TMO(LINKT), .TX_TMO(TXT), .TX_HANDSHAKE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .up_cmd(up_cmd), .down_cmd(down_cmd), .tx_cmd(tx_cmd),
      .cal_clr(cal_clr), .link_sts(link_sts), .tx_pwr_up(tx_pwr_up), .tx_ack(tx_ack),
      .ctrl(ctrl), .link_clr(link_clr), .tx_en(tx_en), .busy(busy), .done(done), .err(err));

   // PHY model: calibration and transmit-enable self-clear after a few cycles
   always @(posedge clk) begin
      cc      <= ctrl[8] ? cc + 1 : 0;
      tc      <= tx_en ? tc + 1 : 0;
   end
   assign cal_clr = cal_ok && ctrl[8] && (cc == 5);
   assign tx_ack  = tx_ok && tx_en && (tc == 4);

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (rst_n) begin
      if (ctrl != prev && n_ch < 32) begin
         ch_val[n_ch] = ctrl;
         ch_t[n_ch]   = cyc;
         n_ch++;
      end
      prev = ctrl;
      if (done) done_cnt++;
      if (err) err_cnt++;
      if (link_clr) clr_cnt++;
      if (link_clr && !done) clr_bad++;
      if (tx_en) tx_seen = 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      prev  = 32'h800000F0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // which: 0 up, 1 down, 2 tx, 3 up and down together
   task automatic run_cmd(input int which, input bit inject);
      n_ch = 0; done_cnt = 0; err_cnt = 0; clr_cnt = 0; clr_bad = 0; tx_seen = 0;
      up_cmd   = (which == 0 || which == 3);
      down_cmd = (which == 1 || which == 3);
      tx_cmd   = (which == 2);
      @(negedge clk);
      up_cmd = 0; down_cmd = 0; tx_cmd = 0;
      for (int k = 0; k < 5000; k++) begin
         if (inject && k == 5) begin down_cmd = 1; tx_cmd = 1; end
         if (inject && k == 6) begin down_cmd = 0; tx_cmd = 0; end
         if (inject && k == 6) check(busy == 1'b1, "R9", "busy mid-run", 32'(busy), 1);
         if (done || err) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   initial begin
      do_reset();
      check(ctrl == 32'h800000F0, "R1", "reset ctrl", ctrl, 32'h800000F0);
      check({busy, done, err, link_clr, tx_en} == 5'b0, "R1", "reset flags",
            32'({busy, done, err, link_clr, tx_en}), 0);

      // Power-up with a down/tx command injected mid-run
      link_sts = 1; cal_ok = 1;
      run_cmd(0, 1'b1);
      check(n_ch == 9, "R2", "up change count", 32'(n_ch), 9);
      for (int i = 0; i < 9; i++)
         check(ch_val[i] == UP_EXP[i], (i < 4) ? "R2" : "R3", $sformatf("up step %0d", i),
               ch_val[i], UP_EXP[i]);
      check(ch_t[2] - ch_t[1] >= GS, "R4", "aux->sleep gap", 32'(ch_t[2] - ch_t[1]), GS);
      check(ch_t[3] - ch_t[2] >= GL, "R4", "sleep->cal gap", 32'(ch_t[3] - ch_t[2]), GL);
      check(ch_t[5] - ch_t[4] >= GS, "R4", "cal->data gap", 32'(ch_t[5] - ch_t[4]), GS);
      check(ch_t[6] - ch_t[5] >= GS, "R4", "rdy low->cdr gap", 32'(ch_t[6] - ch_t[5]), GS);
      check(ch_t[7] - ch_t[6] >= GS, "R4", "cdr->rdy gap", 32'(ch_t[7] - ch_t[6]), GS);
      check(ch_t[8] - ch_t[7] >= HOLD, "R5", "cdr hold", 32'(ch_t[8] - ch_t[7]), HOLD);
      check(clr_cnt == 1 && clr_bad == 0, "R6", "link clear pulses", 32'(clr_cnt), 1);
      check(done_cnt == 1 && err_cnt == 0, "R9", "one done", 32'(done_cnt), 1);
      check(ctrl == 32'h80000401 && !busy, "R9", "injected cmds ignored", ctrl, 32'h80000401);
      check(!tx_seen, "R9", "tx cmd ignored while busy", 32'(tx_seen), 0);

      // Power-down from fully up
      run_cmd(1, 1'b0);
      check(n_ch == 4, "R8", "down change count", 32'(n_ch), 4);
      for (int i = 0; i < 4; i++)
         check(ch_val[i] == DN_EXP[i], "R8", $sformatf("down step %0d", i), ch_val[i], DN_EXP[i]);
      check(done_cnt == 1, "R8", "down done", 32'(done_cnt), 1);

      // Power-down from reset state: no toggling
      do_reset();
      run_cmd(1, 1'b0);
      check(n_ch == 0 && done_cnt == 1, "R8", "down from off", 32'(n_ch), 0);

      // Simultaneous commands: up wins
      do_reset();
      run_cmd(3, 1'b0);
      check(ctrl == 32'h80000401, "R11", "up priority", ctrl, 32'h80000401);

      // Calibration timeout
      do_reset();
      cal_ok = 0;
      run_cmd(0, 1'b0);
      check(err_cnt == 1 && done_cnt == 0, "R7", "cal timeout err", 32'(err_cnt), 1);
      check(ctrl == 32'h80000100 && !busy, "R7", "cal timeout word", ctrl, 32'h80000100);
      cal_ok = 1;

      // Link timeout
      do_reset();
      link_sts = 0;
      run_cmd(0, 1'b0);
      check(err_cnt == 1 && clr_cnt == 0, "R7", "link timeout err", 32'(err_cnt), 1);
      check(ctrl == 32'h80000401 && !busy, "R7", "link timeout word", ctrl, 32'h80000401);

      // Transmit handshake
      do_reset();
      tx_pwr_up = 1;
      run_cmd(2, 1'b0);
      check(done_cnt == 1 && !tx_seen, "R10", "tx already up", 32'(tx_seen), 0);
      tx_pwr_up = 0; tx_ok = 1;
      run_cmd(2, 1'b0);
      check(done_cnt == 1 && tx_seen && !tx_en, "R10", "tx enable acked",
            32'({tx_seen, tx_en}), 32'b10);
      tx_ok = 0;
      run_cmd(2, 1'b0);
      check(err_cnt == 1 && tx_en, "R10", "tx timeout", 32'({err_cnt[0], tx_en}), 32'b11);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule